// File: doc/BRIEF.md
# ID-Ordered Request Stall Demultiplexer

This block steers request beats from one initiator-side address channel, either read or write, to one of several downstream target ports. Each beat arrives with its target index already decoded. The beat passes straight through to the selected port in the same cycle. No register sits in the forward path.

Ordering between transactions that share an ID is kept only by stalling, because the block has no reorder storage. The block keeps a table indexed by the low bits of the ID. Each table entry holds a count of transactions in flight and the target that the oldest of them holds locked. A new beat whose truncated ID is busy toward a different target is held off until every transaction for that ID has been retired. A beat toward the same target is allowed through. A completion input that carries the ID retires one transaction. A global credit counter caps the total number of outstanding transactions.

Comparing fewer ID bits makes the table smaller. The cost is extra stalls between IDs that differ only in their upper bits.

Top module: `idord_stall_demux`

## Requirements
- R1: After reset nothing is outstanding. Every `out_valid_o` bit is low while `req_valid_i` is low, and `req_ready_o` is high whenever the addressed port's `out_ready_i` bit is high.
- R2: A beat is accepted when `req_valid_i` and `req_ready_o` are both high. In that same cycle only bit `req_tgt_i` of `out_valid_o` is high. `out_id_o` and `out_data_o` equal the request's ID and payload.
- R3: Suppose transactions are in flight for a truncated ID and are locked to target A. A beat with that truncated ID and a target other than A sees `req_ready_o` low and all `out_valid_o` bits low.
- R4: A beat whose truncated ID is in flight toward the same target it requests is accepted without stalling.
- R5: Only ID bits [ID_USED-1:0] take part in the comparison. IDs that differ only above that field conflict. IDs that differ inside that field never conflict.
- R6: When MAX_OUT transactions are outstanding, every new beat stalls, even if a completion arrives in the same cycle. Once a completion has been taken, the next beat can be accepted.
- R7: The target lock for an ID is released only when its in-flight count returns to zero. After that, a beat with that ID toward any target can be accepted.
- R8: An accepted beat and a completion that arrive in the same cycle for the same truncated ID leave that ID's count and the total count unchanged.
- R9: Output valid never depends on output ready. When the selected port's `out_ready_i` bit is low, its `out_valid_o` bit still rises for an allowed beat, `req_ready_o` stays low, and nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request beat valid |
| req_ready_o | output | 1 | Request beat accepted |
| req_id_i | input | ID_W | Transaction ID of the beat |
| req_tgt_i | input | TGT_W | Decoded target port index |
| req_data_i | input | DATA_W | Address and attribute payload |
| out_valid_o | output | N_TGT | Per-target valid, at most one bit high |
| out_ready_i | input | N_TGT | Per-target ready |
| out_id_o | output | ID_W | ID forwarded to all targets |
| out_data_o | output | DATA_W | Payload forwarded to all targets |
| done_valid_i | input | 1 | One transaction has completed |
| done_id_i | input | ID_W | ID of the completed transaction |

## Verification
The forward path is combinational, so `out_valid_o`, `req_ready_o` and the forwarded fields settle in the same cycle as the request. The bench drives inputs just after a rising edge and samples them at the following falling edge. The ID table and the credit counter update at the next rising edge. A completion or an acceptance is therefore first visible as a stall decision in the cycle after it. The bench's reference model is updated at that edge, before the next beat is driven. A monitor compares each handshake at the falling edge against the entry that the driver queued for that cycle.

// File: rtl/idord_pkg.sv
package idord_pkg;
  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic int unsigned index_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/idord_id_table.sv
module idord_id_table #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned TGT_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] look_idx_i,
  input  logic             issue_en_i,
  input  logic [TGT_W-1:0] issue_tgt_i,
  input  logic             retire_en_i,
  input  logic [IDX_W-1:0] retire_idx_i,
  output logic             busy_o,
  output logic [TGT_W-1:0] lock_o
);
  localparam int unsigned N_ENT = 1 << IDX_W;

  logic [N_ENT-1:0][CNT_W-1:0] cnt_vec;
  logic [N_ENT-1:0][TGT_W-1:0] lock_vec;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic             inc, dec;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TGT_W-1:0] lock_q, lock_d;
    logic             cnt_en, lock_en;

    assign inc = issue_en_i  && (look_idx_i   == IDX_W'(e));
    assign dec = retire_en_i && (retire_idx_i == IDX_W'(e));

    always_comb begin
      cnt_en  = inc ^ dec;
      cnt_d   = inc ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
      lock_en = inc && (cnt_q == '0);
      lock_d  = issue_tgt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        lock_q <= '0;
      end else begin
        if (cnt_en)  cnt_q  <= cnt_d;
        if (lock_en) lock_q <= lock_d;
      end
    end

    assign cnt_vec[e]  = cnt_q;
    assign lock_vec[e] = lock_q;
  end

  assign busy_o = (cnt_vec[look_idx_i] != '0);
  assign lock_o = lock_vec[look_idx_i];
endmodule

// File: rtl/idord_credit.sv
module idord_credit #(
  parameter int unsigned MAX_OUT = 6,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  output logic             full_o,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] total_q, total_d;
  logic             total_en;

  always_comb begin
    total_en = take_i ^ give_i;
    total_d  = take_i ? total_q + CNT_W'(1) : total_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       total_q <= '0;
    else if (total_en) total_q <= total_d;
  end

  assign full_o  = (total_q == CNT_W'(MAX_OUT));
  assign total_o = total_q;
endmodule

// File: rtl/idord_route.sv
module idord_route #(
  parameter int unsigned N_TGT = 4,
  parameter int unsigned TGT_W = 2
) (
  input  logic             valid_i,
  input  logic             allow_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [N_TGT-1:0] out_ready_i,
  output logic [N_TGT-1:0] out_valid_o,
  output logic             ready_o
);
  logic [N_TGT-1:0] sel;

  for (genvar t = 0; t < N_TGT; t++) begin : g_sel
    assign sel[t] = (tgt_i == TGT_W'(t));
  end

  assign out_valid_o = (valid_i && allow_i) ? sel : '0;
  assign ready_o     = allow_i && |(sel & out_ready_i);
endmodule

// File: rtl/idord_stall_demux.sv
module idord_stall_demux #(
  parameter int unsigned N_TGT   = 4,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned ID_USED = 2,
  parameter int unsigned MAX_OUT = 6,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned TGT_W  = idord_pkg::index_width(N_TGT),
  localparam int unsigned CNT_W  = idord_pkg::width_for(MAX_OUT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [TGT_W-1:0]  req_tgt_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic [N_TGT-1:0]  out_valid_o,
  input  logic [N_TGT-1:0]  out_ready_i,
  output logic [ID_W-1:0]   out_id_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              done_valid_i,
  input  logic [ID_W-1:0]   done_id_i
);
  logic             busy_w, full_w, allow_w, fire_w;
  logic [TGT_W-1:0] lock_w;
  logic [CNT_W-1:0] total_w;

  idord_id_table #(.IDX_W(ID_USED), .TGT_W(TGT_W), .CNT_W(CNT_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .look_idx_i   (req_id_i[ID_USED-1:0]),
    .issue_en_i   (fire_w),
    .issue_tgt_i  (req_tgt_i),
    .retire_en_i  (done_valid_i),
    .retire_idx_i (done_id_i[ID_USED-1:0]),
    .busy_o       (busy_w),
    .lock_o       (lock_w)
  );

  idord_credit #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (fire_w),
    .give_i  (done_valid_i),
    .full_o  (full_w),
    .total_o (total_w)
  );

  assign allow_w = !full_w && !(busy_w && (lock_w != req_tgt_i));

  idord_route #(.N_TGT(N_TGT), .TGT_W(TGT_W)) u_route (
    .valid_i     (req_valid_i),
    .allow_i     (allow_w),
    .tgt_i       (req_tgt_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .ready_o     (req_ready_o)
  );

  assign fire_w     = req_valid_i && req_ready_o;
  assign out_id_o   = req_id_i;
  assign out_data_o = req_data_i;
endmodule

// File: rtl/idord_stall_demux_chk.sv
module idord_stall_demux_chk #(
  parameter int unsigned N_TGT   = 4,
  parameter int unsigned TGT_W   = 2,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned MAX_OUT = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [TGT_W-1:0] req_tgt_i,
  input logic [N_TGT-1:0] out_valid_o,
  input logic [N_TGT-1:0] out_ready_i,
  input logic             done_valid_i,
  input logic             busy,
  input logic [TGT_W-1:0] lock,
  input logic             full,
  input logic [CNT_W-1:0] total
);
  logic [N_TGT-1:0] hs;
  assign hs = out_valid_o & out_ready_i;

  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o));

  a_r2_fire_routed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> |(hs & (N_TGT'(1) << req_tgt_i)));

  a_r3_no_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hs && busy) |-> (lock == req_tgt_i));

  a_r6_no_issue_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !req_ready_o);

  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total <= CNT_W'(MAX_OUT));

  a_r8_balance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && done_valid_i) |=> (total == $past(total)));

  a_r9_valid_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_valid_o && !(|hs)) |-> !req_ready_o);
endmodule

bind idord_stall_demux idord_stall_demux_chk #(
  .N_TGT(N_TGT), .TGT_W(TGT_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_tgt_i    (req_tgt_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .done_valid_i (done_valid_i),
  .busy         (busy_w),
  .lock         (lock_w),
  .full         (full_w),
  .total        (total_w)
);

// File: tb/idord_stall_demux_tb.sv
module idord_stall_demux_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_id = '0;
  logic [1:0] req_tgt = '0;
  logic [7:0] req_data = '0;
  logic [3:0] out_valid;
  logic [3:0] out_ready = 4'hF;
  logic [3:0] out_id;
  logic [7:0] out_data;
  logic       done_valid = 1'b0;
  logic [3:0] done_id = '0;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed { logic [1:0] tgt; logic [3:0] id; logic [7:0] data; } item_t;
  item_t sb[$];

  int cnt_m [4];
  int lock_m [4];
  int total_m = 0;

  always #10 clk = ~clk;

  idord_stall_demux u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_id_i(req_id), .req_tgt_i(req_tgt), .req_data_i(req_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_id_o(out_id), .out_data_o(out_data),
    .done_valid_i(done_valid), .done_id_i(done_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard at each output handshake (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < 4; t++) begin
        if (out_valid[t] && out_ready[t]) begin
          if (sb.size() == 0) begin
            chk("R2 unexpected handshake", {28'd0, 2'(t), 2'd0}, 32'hFFFF);
          end else begin
            item_t e;
            e = sb.pop_front();
            chk("R2 target", t, e.tgt);
            chk("R2 id", out_id, e.id);
            chk("R2 data", out_data, e.data);
          end
        end
      end
    end
  end

  task automatic step(input logic v, input logic [3:0] id, input logic [1:0] tgt,
                      input logic [7:0] dat, input logic dv, input logic [3:0] did,
                      input logic [3:0] rdy, input string tag, output logic acc);
    int ix, dx;
    logic stall, exp_rdy;
    logic [3:0] exp_ov;
    ix = int'(id[1:0]);
    dx = int'(did[1:0]);
    stall = (cnt_m[ix] != 0 && lock_m[ix] != int'(tgt)) || total_m == 6;
    exp_rdy = !stall && rdy[tgt];
    exp_ov = (v && !stall) ? (4'b1 << tgt) : 4'b0;
    acc = v && exp_rdy;
    req_valid = v; req_id = id; req_tgt = tgt; req_data = dat;
    done_valid = dv; done_id = did; out_ready = rdy;
    if (acc) sb.push_back('{tgt: tgt, id: id, data: dat});
    @(negedge clk);
    chk({tag, " ready"}, req_ready, exp_rdy);
    chk({tag, " valid"}, out_valid, exp_ov);
    @(posedge clk);
    #1;
    if (acc) begin
      if (cnt_m[ix] == 0) lock_m[ix] = int'(tgt);
      cnt_m[ix]++;
      total_m++;
    end
    if (dv) begin
      cnt_m[dx]--;
      total_m--;
    end
    req_valid = 1'b0;
    done_valid = 1'b0;
    out_ready = 4'hF;
  endtask

  task automatic drain();
    logic a;
    for (int i = 0; i < 4; i++)
      while (cnt_m[i] > 0) step(1'b0, 4'd0, 2'd0, 8'd0, 1'b1, 4'(i), 4'hF, "drain", a);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic a;
    for (int i = 0; i < 4; i++) begin cnt_m[i] = 0; lock_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    @(negedge clk);
    chk("R1 valid idle", out_valid, 4'h0);
    chk("R1 ready idle", req_ready, 1'b1);
    @(posedge clk); #1;

    step(1'b1, 4'd1, 2'd2, 8'hA1, 1'b0, 4'd0, 4'hF, "R2", a); chk("R2 accept", a, 1);
    step(1'b1, 4'd1, 2'd2, 8'hA2, 1'b0, 4'd0, 4'hF, "R4", a); chk("R4 same target", a, 1);
    step(1'b1, 4'd1, 2'd0, 8'hA3, 1'b0, 4'd0, 4'hF, "R3", a); chk("R3 other target stall", a, 0);
    step(1'b1, 4'd5, 2'd3, 8'hA4, 1'b0, 4'd0, 4'hF, "R5", a); chk("R5 upper bits conflict", a, 0);
    step(1'b1, 4'd2, 2'd3, 8'hA5, 1'b0, 4'd0, 4'hF, "R5", a); chk("R5 low bits differ", a, 1);

    step(1'b0, 4'd0, 2'd0, 8'h00, 1'b1, 4'd1, 4'hF, "R7", a);
    step(1'b1, 4'd1, 2'd0, 8'hA6, 1'b0, 4'd0, 4'hF, "R7", a); chk("R7 still locked", a, 0);
    step(1'b0, 4'd0, 2'd0, 8'h00, 1'b1, 4'd9, 4'hF, "R7", a);
    step(1'b1, 4'd1, 2'd0, 8'hA7, 1'b0, 4'd0, 4'hF, "R7", a); chk("R7 released", a, 1);

    step(1'b1, 4'd1, 2'd0, 8'hA8, 1'b1, 4'd1, 4'hF, "R8", a); chk("R8 issue+retire", a, 1);
    step(1'b1, 4'd1, 2'd3, 8'hA9, 1'b0, 4'd0, 4'hF, "R8", a); chk("R8 count kept", a, 0);
    step(1'b0, 4'd0, 2'd0, 8'h00, 1'b1, 4'd1, 4'hF, "R8", a);
    step(1'b1, 4'd1, 2'd3, 8'hAA, 1'b0, 4'd0, 4'hF, "R8", a); chk("R8 freed after one", a, 1);

    step(1'b1, 4'd3, 2'd1, 8'hAB, 1'b0, 4'd0, 4'b1101, "R9", a); chk("R9 ready low no accept", a, 0);

    for (int k = 0; k < 4; k++) begin
      step(1'b1, 4'd0, 2'd1, 8'(8'hB0 + k), 1'b0, 4'd0, 4'hF, "R6 fill", a);
      chk("R6 fill", a, 1);
    end
    step(1'b1, 4'd0, 2'd1, 8'hC0, 1'b0, 4'd0, 4'hF, "R6", a); chk("R6 cap stall", a, 0);
    step(1'b1, 4'd0, 2'd1, 8'hC1, 1'b1, 4'd0, 4'hF, "R6", a); chk("R6 cap with retire", a, 0);
    step(1'b1, 4'd0, 2'd1, 8'hC2, 1'b0, 4'd0, 4'hF, "R6", a); chk("R6 after retire", a, 1);
    drain();

    // Random traffic: ordering per ID and cap (R3 R4 R5 R6 R8)
    for (int i = 0; i < 600; i++) begin
      logic [3:0] id, did, rdy;
      logic [1:0] tgt;
      logic v, dv;
      int pick;
      id = 4'($urandom);
      tgt = 2'($urandom);
      v = ($urandom % 4) != 0;
      rdy = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
      dv = 1'b0; did = '0;
      pick = int'($urandom % 4);
      if (($urandom % 2) == 0 && cnt_m[pick] > 0) begin
        dv = 1'b1;
        did = {2'($urandom), 2'(pick)};
      end
      step(v, id, tgt, 8'($urandom), dv, did, rdy, "R3 random", a);
    end
    drain();
    step(1'b1, 4'd7, 2'd2, 8'hEE, 1'b0, 4'd0, 4'hF, "R7 end", a); chk("R7 idle end", a, 1);
    drain();
    repeat (2) @(posedge clk);
    chk("R2 scoreboard empty", sb.size(), 0);
    summary();
  end
endmodule